// File: doc/BRIEF.md
# Non-Volatile Memory Checksum Verify and Regenerate Engine

This engine walks the low region of a word-addressed non-volatile memory and adds up the 16-bit words it finds there, with wraparound modulo 2^16. A one-cycle start pulse begins an operation, and a mode select taken with the pulse picks one of two operations. A check run reads every word from address 0 through the checksum slot. It passes only if the total equals the fixed target 0xBABA. A regenerate run reads the words below the checksum slot. It then writes the value that brings the total to the target, which is the target minus the partial sum, into the checksum slot.

Memory traffic goes through two request/acknowledge ports, one for reads and one for writes. The engine has at most one access pending at a time. Each access holds its request until the acknowledge arrives, and an error flag comes back together with the acknowledge. A read error ends the walk at once. A rejected write-back is reported as its own error. The results are a busy level, a one-cycle done pulse and a two-bit status code. The status code holds its value until the next operation completes.

Top module: `nvm_csum_engine`

## Requirements
- R1: After synchronous reset, busy, done, the read request and the write request are all low, and the status is 0 (OK).
- R2: Reads go out one at a time in ascending order from address 0. Each read holds its request and address steady until its acknowledge. A check run reads addresses 0 through CSUM_IDX inclusive.
- R3: The running sum is 16 bits wide and wraps modulo 2^16. A memory of all 0xFFFF words gives the same pass/fail result and the same write-back value as the wrapped arithmetic.
- R4: A check run ends with status 0 (OK) when the wrapped sum equals 0xBABA, and with status 1 (sum mismatch) otherwise.
- R5: A regenerate run reads addresses 0 through CSUM_IDX-1. It then makes exactly one write to address CSUM_IDX with data 0xBABA minus the wrapped sum. An acknowledged write without error gives status 0, and a check run afterwards passes.
- R6: A read acknowledged with its error flag ends the operation. No further read is issued, no write is issued, and the status is 2 (read fault).
- R7: A write acknowledged with its error flag ends the operation with status 3 (write fault).
- R8: A start pulse while busy is ignored, whatever its mode. The running operation keeps its mode, read count and outcome.
- R9: Busy rises the cycle after an accepted start. Done is high for exactly one cycle at the end, and busy falls the cycle after done.
- R10: The read and write requests are never high together, and a check run never writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse, taken only when idle |
| mode_i | input | 1 | 0 = check, 1 = regenerate; sampled with start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 OK, 1 sum mismatch, 2 read fault, 3 write fault |
| rd_req_o | output | 1 | Read request, held until acknowledge |
| rd_addr_o | output | ADDR_W | Read word address |
| rd_ack_i | input | 1 | Read acknowledge |
| rd_err_i | input | 1 | Read error, valid with acknowledge |
| rd_data_i | input | DATA_W | Read data, valid with acknowledge |
| wr_req_o | output | 1 | Write request, held until acknowledge |
| wr_addr_o | output | ADDR_W | Write word address (always the checksum slot) |
| wr_data_o | output | DATA_W | Correction word |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_err_i | input | 1 | Write error, valid with acknowledge |

## Verification
The bench uses memories whose words sum far past 2^16, including all-0xFFFF contents. An engine that saturates or widens its sum would then flag a good image as a mismatch or write a wrong correction. A read error is injected on the first word and on a middle word. A design that kept walking after the error would show extra reads, and one that went on to write-back would show a write. Acknowledges come with varied latency to catch an address that moves before its acknowledge or a read count that is off by one at the checksum slot. A start pulse of the opposite mode is injected mid-run. Re-latching it would turn a check into a write or restart the address walk.

// File: rtl/nvm_csum_pkg.sv
// Package: shared types for the checksum engine.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package nvm_csum_pkg;

    // Outcome codes reported on status_o.
    typedef enum logic [1:0] {
        CS_OK       = 2'd0,
        CS_SUM_BAD  = 2'd1,
        CS_RD_FAULT = 2'd2,
        CS_WR_FAULT = 2'd3
    } cs_status_e;

    // Operation selected with the start pulse.
    typedef enum logic {
        MODE_CHECK = 1'b0,
        MODE_REGEN = 1'b1
    } cs_mode_e;

    // Controller states.
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_READ  = 3'd1,
        S_CHECK = 3'd2,
        S_WRITE = 3'd3,
        S_DONE  = 3'd4
    } cs_state_e;

endpackage

// File: rtl/nvm_csum_addr_seq.sv
// Module: word address sequencer.
// Does: holds the current read address, clears it to zero, and steps it by one
//       on request. Flags when the address equals the supplied last index.
// Assumes: the controller never asks to advance past the last index.
module nvm_csum_addr_seq #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] last_idx_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              at_last_o
);

    logic [ADDR_W-1:0] addr_q;

    // Address register: cleared on a new operation, stepped after each good read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clr_i) begin
            addr_q <= '0;
        end else if (adv_i) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    // Last-word compare drives the controller's end-of-walk decision.
    always_comb begin
        addr_o    = addr_q;
        at_last_o = (addr_q == last_idx_i);
    end

    // The controller only steps while below the last index (R2).
    p_adv_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> (addr_q < last_idx_i));

endmodule

// File: rtl/nvm_csum_accum.sv
// Module: modular word accumulator.
// Does: keeps a DATA_W-bit running sum that wraps on overflow. Reports whether
//       the sum matches the target and forms the correction target - sum.
// Assumes: clear and add are never requested in the same cycle.
module nvm_csum_accum #(
    parameter int                DATA_W     = 16,
    parameter logic [DATA_W-1:0] SUM_TARGET = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              add_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              match_o,
    output logic [DATA_W-1:0] fix_o
);

    logic [DATA_W-1:0] sum_q;

    // Running sum: zeroed on a new operation, wraps modulo 2^DATA_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (clr_i) begin
            sum_q <= '0;
        end else if (add_i) begin
            sum_q <= sum_q + word_i;
        end
    end

    // Compare and correction value, both taken from the settled sum.
    always_comb begin
        match_o = (sum_q == SUM_TARGET);
        fix_o   = SUM_TARGET - sum_q;
    end

    // Clear and accumulate come from exclusive controller states (R3).
    p_no_clr_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_i && add_i));

endmodule

// File: rtl/nvm_csum_ctrl.sv
// Module: operation controller.
// Does: accepts start when idle, latches the mode, and issues reads one at a
//       time. On the last read it moves to the compare or the write-back.
//       It ends on the first read error or on the write acknowledge, with a
//       one-cycle done pulse and a held status code.
// Assumes: acknowledges arrive only while the matching request is high.
module nvm_csum_ctrl
    import nvm_csum_pkg::*;
#(
    parameter bit REGEN_EMPTY = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       mode_i,
    input  logic       rd_ack_i,
    input  logic       rd_err_i,
    input  logic       wr_ack_i,
    input  logic       wr_err_i,
    input  logic       at_last_i,
    input  logic       sum_match_i,
    output logic       rd_req_o,
    output logic       wr_req_o,
    output logic       seq_clr_o,
    output logic       seq_adv_o,
    output logic       acc_clr_o,
    output logic       acc_add_o,
    output logic       regen_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] status_o
);

    cs_state_e  state_q, state_d;
    cs_mode_e   mode_q;
    cs_status_e status_q, status_d;
    logic       accept;

    // Start is taken only from idle; any pulse while busy is dropped.
    always_comb begin
        accept = (state_q == S_IDLE) && start_i;
    end

    // Next-state, datapath strobes and completion code.
    always_comb begin
        state_d   = state_q;
        status_d  = status_q;
        seq_clr_o = 1'b0;
        seq_adv_o = 1'b0;
        acc_clr_o = 1'b0;
        acc_add_o = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    seq_clr_o = 1'b1;
                    acc_clr_o = 1'b1;
                    if ((cs_mode_e'(mode_i) == MODE_REGEN) && REGEN_EMPTY) begin
                        state_d = S_WRITE;
                    end else begin
                        state_d = S_READ;
                    end
                end
            end
            S_READ: begin
                if (rd_ack_i) begin
                    if (rd_err_i) begin
                        status_d = CS_RD_FAULT;
                        state_d  = S_DONE;
                    end else begin
                        acc_add_o = 1'b1;
                        if (at_last_i) begin
                            state_d = (mode_q == MODE_REGEN) ? S_WRITE : S_CHECK;
                        end else begin
                            seq_adv_o = 1'b1;
                        end
                    end
                end
            end
            S_CHECK: begin
                status_d = sum_match_i ? CS_OK : CS_SUM_BAD;
                state_d  = S_DONE;
            end
            S_WRITE: begin
                if (wr_ack_i) begin
                    status_d = wr_err_i ? CS_WR_FAULT : CS_OK;
                    state_d  = S_DONE;
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // State, mode and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            mode_q   <= MODE_CHECK;
            status_q <= CS_OK;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
            if (accept) begin
                mode_q <= cs_mode_e'(mode_i);
            end
        end
    end

    // Port-facing decodes of the state.
    always_comb begin
        rd_req_o = (state_q == S_READ);
        wr_req_o = (state_q == S_WRITE);
        regen_o  = (mode_q == MODE_REGEN);
        busy_o   = (state_q != S_IDLE);
        done_o   = (state_q == S_DONE);
        status_o = status_q;
    end

    // Done lasts a single cycle (R9).
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Busy drops right after done (R9).
    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // A failed read ends the walk with no further traffic (R6).
    p_rd_err_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i && rd_err_i) |=> (done_o && !rd_req_o && !wr_req_o));

    // A start seen while busy leaves the latched mode alone (R8).
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(mode_q));

    // Writes happen only in regenerate runs (R10).
    p_wr_only_regen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (mode_q == MODE_REGEN));

endmodule

// File: rtl/nvm_csum_engine.sv
// Module: checksum verify/regenerate engine (top).
// Does: ties the controller, the address sequencer and the accumulator to the
//       read and write request/acknowledge ports. Check runs read words
//       0..CSUM_IDX; regenerate runs read 0..CSUM_IDX-1 and write the
//       correction word to CSUM_IDX.
// Assumes: CSUM_IDX fits in ADDR_W bits; the memory side holds at most one
//          acknowledge per request and returns data and error with it.
module nvm_csum_engine
    import nvm_csum_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 16,
    parameter int                CSUM_IDX   = 63,
    parameter logic [DATA_W-1:0] SUM_TARGET = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        status_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic              rd_err_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic              wr_ack_i,
    input  logic              wr_err_i
);

    localparam logic [ADDR_W-1:0] CHECK_LAST  = ADDR_W'(CSUM_IDX);
    localparam bit                REGEN_EMPTY = (CSUM_IDX == 0);
    localparam logic [ADDR_W-1:0] REGEN_LAST  = REGEN_EMPTY ? '0 : ADDR_W'(CSUM_IDX - 1);

    logic              seq_clr, seq_adv, acc_clr, acc_add, regen;
    logic              at_last, sum_match;
    logic [ADDR_W-1:0] last_idx;
    logic [DATA_W-1:0] fix_word;

    // The last index read depends on the latched mode.
    always_comb begin
        last_idx = regen ? REGEN_LAST : CHECK_LAST;
    end

    nvm_csum_ctrl #(
        .REGEN_EMPTY (REGEN_EMPTY)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .rd_ack_i    (rd_ack_i),
        .rd_err_i    (rd_err_i),
        .wr_ack_i    (wr_ack_i),
        .wr_err_i    (wr_err_i),
        .at_last_i   (at_last),
        .sum_match_i (sum_match),
        .rd_req_o    (rd_req_o),
        .wr_req_o    (wr_req_o),
        .seq_clr_o   (seq_clr),
        .seq_adv_o   (seq_adv),
        .acc_clr_o   (acc_clr),
        .acc_add_o   (acc_add),
        .regen_o     (regen),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .status_o    (status_o)
    );

    nvm_csum_addr_seq #(
        .ADDR_W (ADDR_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (seq_clr),
        .adv_i      (seq_adv),
        .last_idx_i (last_idx),
        .addr_o     (rd_addr_o),
        .at_last_o  (at_last)
    );

    nvm_csum_accum #(
        .DATA_W     (DATA_W),
        .SUM_TARGET (SUM_TARGET)
    ) acc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (acc_clr),
        .add_i   (acc_add),
        .word_i  (rd_data_i),
        .match_o (sum_match),
        .fix_o   (fix_word)
    );

    // Write-back always targets the checksum slot with the correction word.
    always_comb begin
        wr_addr_o = CHECK_LAST;
        wr_data_o = fix_word;
    end

    // A pending read keeps its request and address until acknowledged (R2).
    p_rd_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

    // A pending write keeps its data until acknowledged (R5).
    p_wr_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_data_o)));

    // Only one access is ever outstanding (R10).
    p_no_rw_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o));

endmodule

// File: tb/nvm_csum_engine_tb_top.sv
// Bench: vector table of runs walked by one loop, then directed cases.
// A memory model at the negative edge answers reads and writes with a
// programmable latency and injected errors.
module nvm_csum_engine_tb_top;

    localparam int          AW     = 8;
    localparam int          DW     = 16;
    localparam int          CSUM   = 63;
    localparam logic [15:0] TARGET = 16'hBABA;

    typedef struct packed {
        logic       mode;
        logic [1:0] fill;
        logic       fix;
        logic       rerr;
        logic [7:0] rerr_at;
        logic       werr;
        logic [2:0] lat;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd0, 1'b1, 1'b0, 8'd0,  1'b0, 3'd0},
        '{1'b0, 2'd1, 1'b1, 1'b0, 8'd0,  1'b0, 3'd2},
        '{1'b0, 2'd3, 1'b0, 1'b0, 8'd0,  1'b0, 3'd1},
        '{1'b1, 2'd0, 1'b0, 1'b0, 8'd0,  1'b0, 3'd0},
        '{1'b1, 2'd1, 1'b0, 1'b0, 8'd0,  1'b0, 3'd3},
        '{1'b0, 2'd2, 1'b1, 1'b1, 8'd20, 1'b0, 3'd1},
        '{1'b1, 2'd3, 1'b0, 1'b1, 8'd0,  1'b0, 3'd0},
        '{1'b1, 2'd2, 1'b0, 1'b0, 8'd0,  1'b1, 3'd2},
        '{1'b0, 2'd2, 1'b0, 1'b0, 8'd0,  1'b0, 3'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic          busy, done;
    logic [1:0]    status;
    logic          rd_req, rd_ack, rd_err;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          wr_req, wr_ack, wr_err;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    logic [15:0]   mem [256];
    int            cur_lat = 0;
    logic          rerr_en = 1'b0;
    logic [7:0]    rerr_at = '0;
    logic          werr_en = 1'b0;

    int            lat_cnt = 0;
    int            rd_seq = 0;
    int            wr_seq = 0;
    logic          order_bad = 1'b0;
    logic          overlap = 1'b0;
    logic [15:0]   wr_val = '0;
    logic [7:0]    wr_at = '0;

    int            tests = 0;
    int            fails = 0;

    always #4 clk = ~clk;

    nvm_csum_engine #(
        .ADDR_W (AW), .DATA_W (DW), .CSUM_IDX (CSUM), .SUM_TARGET (TARGET)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start), .mode_i (mode),
        .busy_o (busy), .done_o (done), .status_o (status),
        .rd_req_o (rd_req), .rd_addr_o (rd_addr), .rd_ack_i (rd_ack),
        .rd_err_i (rd_err), .rd_data_i (rd_data),
        .wr_req_o (wr_req), .wr_addr_o (wr_addr), .wr_data_o (wr_data),
        .wr_ack_i (wr_ack), .wr_err_i (wr_err)
    );

    // Memory model: answers at the negative edge, logs per-run traffic.
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_ack <= 1'b0; rd_err <= 1'b0; wr_ack <= 1'b0; wr_err <= 1'b0;
            rd_data <= '0; lat_cnt <= 0;
        end else begin
            rd_ack <= 1'b0; rd_err <= 1'b0; wr_ack <= 1'b0; wr_err <= 1'b0;
            if (!busy) begin
                rd_seq <= 0; wr_seq <= 0; order_bad <= 1'b0; overlap <= 1'b0;
            end
            if (rd_req && wr_req) overlap <= 1'b1;
            if (rd_req && !rd_ack) begin
                if (lat_cnt >= cur_lat) begin
                    rd_ack  <= 1'b1;
                    rd_data <= mem[rd_addr];
                    rd_err  <= rerr_en && (rd_addr == rerr_at);
                    if (int'(rd_addr) != rd_seq) order_bad <= 1'b1;
                    rd_seq  <= rd_seq + 1;
                    lat_cnt <= 0;
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end else if (wr_req && !wr_ack) begin
                if (lat_cnt >= cur_lat) begin
                    wr_ack <= 1'b1;
                    wr_err <= werr_en;
                    wr_val <= wr_data;
                    wr_at  <= wr_addr;
                    if (!werr_en) mem[wr_addr] <= wr_data;
                    wr_seq  <= wr_seq + 1;
                    lat_cnt <= 0;
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sum_to(input int n);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = s + mem[i];
        return s;
    endfunction

    task automatic fill_mem(input logic [1:0] kind, input logic fix);
        for (int i = 0; i < 256; i++) begin
            case (kind)
                2'd0:    mem[i] = 16'(i * 16'h1111 + 3);
                2'd1:    mem[i] = 16'hFFFF;
                2'd2:    mem[i] = 16'h0000;
                default: mem[i] = 16'(i) ^ 16'hA5A5;
            endcase
        end
        if (fix) mem[CSUM] = TARGET - sum_to(CSUM);
    endtask

    // One operation: start, optional mid-run opposite-mode start, wait for done.
    task automatic run_op(input logic m, input logic poke, output int st,
                          output int nrd, output int nwr, output logic ord_bad,
                          output logic ovl, output logic pulse_ok);
        int guard;
        @(negedge clk);
        start = 1'b1; mode = m;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9 busy after start", int'(busy), 1);
        if (poke) begin
            repeat (8) @(negedge clk);
            start = 1'b1; mode = ~m;
            @(negedge clk);
            start = 1'b0; mode = m;
        end
        guard = 0;
        while (done !== 1'b1 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        st = int'(status); nrd = rd_seq; nwr = wr_seq;
        ord_bad = order_bad; ovl = overlap;
        @(negedge clk);
        pulse_ok = (guard < 3000) && (done === 1'b0) && (busy === 1'b0);
    endtask

    initial begin
        int   st, nrd, nwr, exp_st, exp_rd, exp_wr;
        logic ob, ov, pk;
        logic [15:0] exp_fix;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && done === 1'b0, "R1 busy/done idle", int'({busy, done}), 0);
        chk(status === 2'd0, "R1 status OK", int'(status), 0);
        chk(rd_req === 1'b0 && wr_req === 1'b0, "R1 no requests", int'({rd_req, wr_req}), 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            fill_mem(VEC[v].fill, VEC[v].fix);
            cur_lat = int'(VEC[v].lat);
            rerr_en = VEC[v].rerr; rerr_at = VEC[v].rerr_at; werr_en = VEC[v].werr;
            exp_fix = TARGET - sum_to(CSUM);
            if (VEC[v].rerr) begin
                exp_st = 2; exp_rd = int'(VEC[v].rerr_at) + 1; exp_wr = 0;
            end else if (VEC[v].mode == 1'b0) begin
                exp_st = (sum_to(CSUM + 1) == TARGET) ? 0 : 1; exp_rd = CSUM + 1; exp_wr = 0;
            end else begin
                exp_st = VEC[v].werr ? 3 : 0; exp_rd = CSUM; exp_wr = 1;
            end
            run_op(VEC[v].mode, 1'b0, st, nrd, nwr, ob, ov, pk);
            // R4 / R5 / R6 / R7 outcome, R3 exercised by the wrapping fills
            chk(st == exp_st, $sformatf("R4 R5 R6 R7 status v%0d", v), st, exp_st);
            chk(nrd == exp_rd, $sformatf("R2 R6 read count v%0d", v), nrd, exp_rd);
            chk(!ob, $sformatf("R2 read order v%0d", v), int'(ob), 0);
            chk(nwr == exp_wr, $sformatf("R5 R10 write count v%0d", v), nwr, exp_wr);
            chk(!ov, $sformatf("R10 overlap v%0d", v), int'(ov), 0);
            chk(pk, $sformatf("R9 done pulse v%0d", v), int'(pk), 1);
            if (exp_wr == 1) begin
                chk(wr_val == exp_fix, $sformatf("R3 R5 write value v%0d", v), int'(wr_val), int'(exp_fix));
                chk(wr_at == 8'(CSUM), $sformatf("R5 write addr v%0d", v), int'(wr_at), CSUM);
            end
            if (VEC[v].mode && !VEC[v].werr && !VEC[v].rerr) begin
                werr_en = 1'b0;
                run_op(1'b0, 1'b0, st, nrd, nwr, ob, ov, pk);
                chk(st == 0, $sformatf("R5 recheck passes v%0d", v), st, 0);
            end
            if (VEC[v].werr) begin
                chk(mem[CSUM] == 16'h0000, "R7 rejected write left slot", int'(mem[CSUM]), 0);
            end
        end

        // R8: opposite-mode start mid check run is ignored
        fill_mem(2'd0, 1'b1);
        cur_lat = 1; rerr_en = 1'b0; werr_en = 1'b0;
        run_op(1'b0, 1'b1, st, nrd, nwr, ob, ov, pk);
        chk(st == 0, "R8 outcome unchanged", st, 0);
        chk(nrd == CSUM + 1, "R8 read count unchanged", nrd, CSUM + 1);
        chk(nwr == 0, "R8 no write from ignored start", nwr, 0);
        chk(!ob, "R8 no address restart", int'(ob), 0);

        // R8: ignored check-mode start during regenerate still writes
        fill_mem(2'd3, 1'b0);
        exp_fix = TARGET - sum_to(CSUM);
        run_op(1'b1, 1'b1, st, nrd, nwr, ob, ov, pk);
        chk(nwr == 1 && wr_val == exp_fix, "R8 regen kept mode", int'(wr_val), int'(exp_fix));

        // R4: corrupted checksum by one fails
        fill_mem(2'd1, 1'b1);
        mem[CSUM] = mem[CSUM] + 16'd1;
        run_op(1'b0, 1'b0, st, nrd, nwr, ob, ov, pk);
        chk(st == 1, "R4 off-by-one sum flagged", st, 1);

        // R6: error on the checksum word itself during check
        fill_mem(2'd0, 1'b1);
        rerr_en = 1'b1; rerr_at = 8'(CSUM);
        run_op(1'b0, 1'b0, st, nrd, nwr, ob, ov, pk);
        chk(st == 2 && nrd == CSUM + 1, "R6 error on last word", st, 2);
        rerr_en = 1'b0;

        // R1: status held while idle after completion
        repeat (4) @(negedge clk);
        chk(status === 2'd2 && busy === 1'b0, "R1 R9 status held idle", int'(status), 2);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R9 watchdog actual=hang expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule